// File: doc/BRIEF.md
# Register Bank with Arithmetic/Logic Execute Stage

This block is the execute half of a single-cycle processor datapath. It holds thirty-two 32-bit general registers and an arithmetic/logic unit. Two register numbers select the operands. The first operand always comes from a register. The second comes either from a register or from an already sign-extended 32-bit immediate. The unit result is offered on an output and, when the write enable is high, is stored into a destination register at the next rising clock edge.

Decode and control logic sit outside the block. They supply the register numbers, the write enable, the operand select and a 4-bit operation code each cycle. The block reports the result and a flag that says whether the result is zero. It also passes through the second register's read data, so that a later store path can use it.

Top module: `regalu_datapath`

## Requirements
- R1: An active-low reset (`rst_n` = 0) clears every register to zero.
- R2: Both reads are combinational. `rd_data_b` shows the register chosen by `rd_sel_b` in the same cycle, and the first operand is the register chosen by `rd_sel_a`.
- R3: When `wr_en` is 1, the result is stored into register `wr_sel` at the rising clock edge and can be read from the next cycle on. When `wr_en` is 0, no register changes.
- R4: Register 0 always reads as zero. A write aimed at it has no effect.
- R5: With `use_imm` = 1 the second operand is `imm_ext`, otherwise it is register `rd_sel_b`. `rd_data_b` always shows the register, whatever `use_imm` is.
- R6: `alu_ctl` selects the operation. 4'b0000 is bitwise AND, 4'b0001 is bitwise OR, 4'b0010 is addition and 4'b0110 is subtraction (first minus second). Addition and subtraction wrap modulo 2^32.
- R7: `alu_ctl` = 4'b0111 (set-less-than) gives 1 when the first operand is below the second as two's-complement numbers, and 0 otherwise. The answer is correct even when the subtraction overflows.
- R8: Any other `alu_ctl` value gives a result of zero.
- R9: `is_zero` is 1 exactly when `alu_out` is zero.
- R10: When a register is read and written in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers are written on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_a | input | 5 | Register number of the first operand |
| rd_sel_b | input | 5 | Register number of the second read |
| wr_sel | input | 5 | Destination register number |
| imm_ext | input | 32 | Sign-extended immediate operand |
| wr_en | input | 1 | Write the result into the destination register |
| use_imm | input | 1 | Choose the immediate as the second operand |
| alu_ctl | input | 4 | Operation code |
| alu_out | output | 32 | Operation result |
| is_zero | output | 1 | High when the result is zero |
| rd_data_b | output | 32 | Data read from register `rd_sel_b` |

## Verification
The assertions check, on every cycle:
- register 0 reads as zero;
- a completed write shows up on a later read of that register;
- set-less-than yields only 0 or 1;
- unknown codes yield zero;
- the zero flag matches the result;
- adding an immediate to register 0 returns that immediate.

Only the bench's scenarios can show that each operation computes the right value on real operands. The same holds for the signed-overflow cases of set-less-than, for reset clearing the whole bank, for a disabled write leaving its target unchanged, and for a read in the writing cycle returning the old value.

// File: rtl/regalu_pkg.sv
package regalu_pkg;
    parameter int DATA_W = 32;
    parameter int REG_N  = 32;
    parameter int CTL_W  = 4;

    typedef enum logic [CTL_W-1:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111
    } alu_op_e;
endpackage

// File: rtl/regalu_regbank.sv
module regalu_regbank
    import regalu_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int DEPTH = REG_N,
    parameter int PORTS = 2,
    localparam int SEL_W = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PORTS-1:0][SEL_W-1:0] rd_sel,
    output logic [PORTS-1:0][W-1:0]     rd_data,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            wr_sel,
    input  logic [W-1:0]                wr_data
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] regs;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en && (wr_sel != '0) && (int'(wr_sel) < DEPTH)) begin
            bank_d.regs[wr_sel] = wr_data;
        end
        bank_d.regs[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        always_comb begin
            if (rd_sel[p] == '0 || int'(rd_sel[p]) >= DEPTH) begin
                rd_data[p] = '0;
            end else begin
                rd_data[p] = bank_q.regs[rd_sel[p]];
            end
        end
    end
endmodule

// File: rtl/regalu_opsel.sv
module regalu_opsel
    import regalu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         use_imm,
    input  logic [W-1:0] reg_val,
    input  logic [W-1:0] imm_val,
    output logic [W-1:0] operand
);
    always_comb begin
        operand = use_imm ? imm_val : reg_val;
    end
endmodule

// File: rtl/regalu_alu.sv
module regalu_alu
    import regalu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [CTL_W-1:0] ctl,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    output logic [W-1:0]     result,
    output logic             zero
);
    logic [W-1:0] sum, diff;
    logic         ovf_sub, less;

    always_comb begin
        sum     = opa + opb;
        diff    = opa + ~opb + {{(W-1){1'b0}}, 1'b1};
        ovf_sub = (opa[W-1] != opb[W-1]) && (diff[W-1] != opa[W-1]);
        less    = diff[W-1] ^ ovf_sub;
        unique case (ctl)
            OP_AND:  result = opa & opb;
            OP_OR:   result = opa | opb;
            OP_ADD:  result = sum;
            OP_SUB:  result = diff;
            OP_SLT:  result = {{(W-1){1'b0}}, less};
            default: result = '0;
        endcase
        zero = ~|result;
    end
endmodule

// File: rtl/regalu_datapath.sv
module regalu_datapath
    import regalu_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int DEPTH = REG_N,
    localparam int SEL_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rd_sel_a,
    input  logic [SEL_W-1:0] rd_sel_b,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     imm_ext,
    input  logic             wr_en,
    input  logic             use_imm,
    input  logic [CTL_W-1:0] alu_ctl,
    output logic [W-1:0]     alu_out,
    output logic             is_zero,
    output logic [W-1:0]     rd_data_b
);
    logic [1:0][SEL_W-1:0] sel_pair;
    logic [1:0][W-1:0]     data_pair;
    logic [W-1:0]          op_b;

    assign sel_pair  = {rd_sel_b, rd_sel_a};
    assign rd_data_b = data_pair[1];

    regalu_regbank #(.W(W), .DEPTH(DEPTH), .PORTS(2)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_sel  (sel_pair),
        .rd_data (data_pair),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (alu_out)
    );

    regalu_opsel #(.W(W)) u_opsel (
        .use_imm (use_imm),
        .reg_val (data_pair[1]),
        .imm_val (imm_ext),
        .operand (op_b)
    );

    regalu_alu #(.W(W)) u_alu (
        .ctl    (alu_ctl),
        .opa    (data_pair[0]),
        .opb    (op_b),
        .result (alu_out),
        .zero   (is_zero)
    );
endmodule

// File: rtl/regalu_datapath_chk.sv
module regalu_datapath_chk
    import regalu_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int DEPTH = REG_N,
    localparam int SEL_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] rd_sel_a,
    input logic [SEL_W-1:0] rd_sel_b,
    input logic [SEL_W-1:0] wr_sel,
    input logic [W-1:0]     imm_ext,
    input logic             wr_en,
    input logic             use_imm,
    input logic [CTL_W-1:0] alu_ctl,
    input logic [W-1:0]     alu_out,
    input logic             is_zero,
    input logic [W-1:0]     rd_data_b
);
    AST_REG0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel_b == '0) |-> (rd_data_b == '0)); // R4

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && ($past(wr_sel) != '0) && (rd_sel_b == $past(wr_sel)))
        |-> (rd_data_b == $past(alu_out))); // R3

    AST_SLT_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_ctl == OP_SLT) |-> (alu_out[W-1:1] == '0)); // R7

    AST_BADOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(alu_ctl inside {OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT}) |-> (alu_out == '0)); // R8

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        is_zero == (alu_out == '0)); // R9

    AST_IMM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (use_imm && rd_sel_a == '0 && alu_ctl == OP_ADD) |-> (alu_out == imm_ext)); // R5
endmodule

bind regalu_datapath regalu_datapath_chk #(.W(W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/regalu_datapath_test.sv
module regalu_datapath_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_sel_a = '0, rd_sel_b = '0, wr_sel = '0;
    logic [31:0] imm_ext = '0;
    logic        wr_en = 1'b0, use_imm = 1'b0;
    logic [3:0]  alu_ctl = '0;
    logic [31:0] alu_out, rd_data_b;
    logic        is_zero;

    int errors = 0;
    int checks = 0;
    logic [31:0] model [32];

    always #4 clk = ~clk;

    regalu_datapath uut (
        .clk(clk), .rst_n(rst_n), .rd_sel_a(rd_sel_a), .rd_sel_b(rd_sel_b),
        .wr_sel(wr_sel), .imm_ext(imm_ext), .wr_en(wr_en), .use_imm(use_imm),
        .alu_ctl(alu_ctl), .alu_out(alu_out), .is_zero(is_zero), .rd_data_b(rd_data_b)
    );

    function automatic logic [31:0] ref_alu(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
        case (c)
            4'b0000: return a & b;
            4'b0001: return a | b;
            4'b0010: return a + b;
            4'b0110: return a - b;
            4'b0111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string op_tag(input logic [3:0] c);
        case (c)
            4'b0000, 4'b0001, 4'b0010, 4'b0110: return "R6";
            4'b0111: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; checks before the rising edge, returns at the next falling edge.
    task automatic do_op(input logic [4:0] a, input logic [4:0] b, input logic [4:0] w,
                         input logic [31:0] imm, input logic we, input logic src, input logic [3:0] c);
        logic [31:0] exp;
        rd_sel_a = a; rd_sel_b = b; wr_sel = w; imm_ext = imm;
        wr_en = we; use_imm = src; alu_ctl = c;
        #1;
        exp = ref_alu(c, model[a], src ? imm : model[b]);
        check({op_tag(c), " result (R2 R5)"}, alu_out, exp);
        check("R9 zero flag", {31'd0, is_zero}, {31'd0, exp == 32'd0});
        check((we && w == b) ? "R10 read during write" : "R2 R5 read data b", rd_data_b, model[b]);
        @(posedge clk);
        if (we && w != 5'd0) model[w] = exp;
        @(negedge clk);
    endtask

    task automatic load(input logic [4:0] r, input logic [31:0] v);
        do_op(5'd0, 5'd0, r, v, 1'b1, 1'b1, 4'b0010);
    endtask

    task automatic read_b(input string tag, input logic [4:0] r, input logic [31:0] exp);
        rd_sel_b = r; wr_en = 1'b0;
        #1;
        check(tag, rd_data_b, exp);
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < 32; i++) model[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every register is clear after reset
        for (int i = 0; i < 32; i++) read_b("R1 reset clears bank", 5'(i), 32'd0);

        // R3: fill the bank through add-immediate and read it back
        for (int i = 1; i < 32; i++) load(5'(i), $urandom);
        for (int i = 1; i < 32; i++) read_b("R3 written value", 5'(i), model[i]);

        // R4: a write to register 0 is ignored
        load(5'd0, 32'hDEAD_BEEF);
        read_b("R4 register 0 stays zero", 5'd0, 32'd0);

        // R3: disabled write leaves the target unchanged
        do_op(5'd3, 5'd4, 5'd7, 32'h1234_5678, 1'b0, 1'b1, 4'b0001);
        read_b("R3 disabled write", 5'd7, model[7]);

        // R10: read and write the same register in one cycle
        do_op(5'd5, 5'd5, 5'd5, 32'd0, 1'b1, 1'b0, 4'b0010);
        read_b("R10 value after write", 5'd5, model[5]);

        // R9: subtraction of equal values gives zero
        do_op(5'd6, 5'd6, 5'd0, 32'd0, 1'b0, 1'b0, 4'b0110);

        // R7: set-less-than across signed overflow
        load(5'd1, 32'h8000_0000);
        load(5'd2, 32'h0000_0001);
        load(5'd3, 32'h7FFF_FFFF);
        load(5'd4, 32'hFFFF_FFFF);
        do_op(5'd1, 5'd2, 5'd8, 32'd0, 1'b1, 1'b0, 4'b0111);
        read_b("R7 min < 1", 5'd8, 32'd1);
        do_op(5'd3, 5'd1, 5'd8, 32'd0, 1'b1, 1'b0, 4'b0111);
        read_b("R7 max not < min", 5'd8, 32'd0);
        do_op(5'd1, 5'd3, 5'd8, 32'd0, 1'b1, 1'b0, 4'b0111);
        read_b("R7 min < max", 5'd8, 32'd1);
        do_op(5'd4, 5'd0, 5'd8, 32'd0, 1'b1, 1'b0, 4'b0111);
        read_b("R7 -1 < 0", 5'd8, 32'd1);
        do_op(5'd3, 5'd0, 5'd0, 32'hFFFF_FFFF, 1'b0, 1'b1, 4'b0111);

        // R6: wrap-around of add and sub
        do_op(5'd3, 5'd2, 5'd9, 32'd0, 1'b1, 1'b0, 4'b0010);
        read_b("R6 add wraps", 5'd9, 32'h8000_0000);
        do_op(5'd1, 5'd2, 5'd9, 32'd0, 1'b1, 1'b0, 4'b0110);
        read_b("R6 sub wraps", 5'd9, 32'h7FFF_FFFF);

        // R8: every unused code yields zero
        for (int c = 0; c < 16; c++) begin
            if (!(c inside {0, 1, 2, 6, 7})) do_op(5'd4, 5'd4, 5'd0, 32'hFFFF_FFFF, 1'b0, 1'b1, 4'(c));
        end

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [3:0]  c;
            logic [31:0] imm;
            logic [2:0]  pick;
            pick = 3'($urandom_range(0, 6));
            case (pick)
                3'd0: c = 4'b0000;
                3'd1: c = 4'b0001;
                3'd2: c = 4'b0010;
                3'd3: c = 4'b0110;
                3'd4, 3'd5: c = 4'b0111;
                default: c = 4'($urandom);
            endcase
            case ($urandom_range(0, 5))
                0: imm = 32'h8000_0000;
                1: imm = 32'h7FFF_FFFF;
                2: imm = 32'hFFFF_FFFF;
                default: imm = $urandom;
            endcase
            do_op(5'($urandom), 5'($urandom), 5'($urandom), imm,
                  1'($urandom), 1'($urandom), c);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule